// File: doc/BRIEF.md
# CAN Receive Double-Buffer Status Controller

This block sits between the receive side of a CAN controller and the CPU. It tracks two receive message buffers: the one the CPU currently owns and a second one that the receiver can fill in the background. It raises a buffer-status output whenever the CPU's buffer holds a fresh message. A release strobe from the CPU hands that buffer back. If the second buffer is already full at that moment, ownership swaps at once and the status stays raised.

Five event flags are collected in an 8-bit interrupt register: receive, transmit, error, overrun and wake-up. Every flag is read-only, and a read strobe clears all of them. A single interrupt request fires when a flag is pending. After it fires, no further request can fire until the CPU reads the register. A sleep bit can be set by the CPU. Bus activity seen while asleep clears the sleep bit and raises the wake-up flag. The bit timing, framing, error counting and message storage are handled elsewhere.

Top module: `can_rxb_ctrl`

## Requirements
- R1: `int_reg_o` layout: bit 0 receive flag, bit 1 transmit flag, bit 2 error flag, bit 3 overrun flag, bit 4 wake-up flag; bits 7..5 always read 0.
- R2: A cycle with `rd_i` high clears every flag at the next clock edge, unless a set event for that flag falls in the same cycle.
- R3: A message arriving while the CPU buffer is empty sets `rbs_o` and the receive flag at the next edge; one arriving while only the CPU buffer is full fills the second buffer and sets no flag.
- R4: `rrb_i` while the second buffer is empty clears `rbs_o` at the next edge, leaving `cpu_buf_o` unchanged.
- R5: `rrb_i` while the second buffer is full keeps `rbs_o` at 1, sets the receive flag again and toggles `cpu_buf_o` at the next edge.
- R6: A message arriving while both buffers are full and no release is given sets the overrun flag and is dropped; two releases then empty both buffers.
- R7: `tx_done_i` sets the transmit flag and `err_evt_i` sets the error flag at the next edge.
- R8: `bus_act_i` while `sleep_o` is 1 clears `sleep_o` and sets the wake-up flag at the next edge; while awake it has no effect. `sleep_req_i` sets `sleep_o`.
- R9: `irq_o` is 1 in a cycle where a flag is set and requests are armed; after one such cycle requests stay disarmed until a cycle with `rd_i`.
- R10: When a set event and `rd_i` fall in the same cycle, the flag is 1 after the edge.
- R11: Reset (`rst_ni` low) empties both buffers, clears all flags and `sleep_o`, sets `cpu_buf_o` to 0 and arms requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_arrive_i | input | 1 | One-cycle pulse: receiver has a complete message |
| tx_done_i | input | 1 | One-cycle pulse: transmission complete |
| err_evt_i | input | 1 | One-cycle pulse: error condition |
| bus_act_i | input | 1 | Bus activity detected |
| rrb_i | input | 1 | CPU release of its receive buffer |
| rd_i | input | 1 | CPU read of the interrupt register |
| sleep_req_i | input | 1 | CPU request to enter sleep |
| sleep_o | output | 1 | Sleep bit |
| rbs_o | output | 1 | CPU buffer holds a new message |
| cpu_buf_o | output | 1 | Index of the buffer the CPU owns |
| irq_o | output | 1 | Interrupt request |
| int_reg_o | output | 8 | Interrupt register value |

## Verification
The read-clear and a flag-set event can fall in the same cycle. So can a buffer release and a message arrival. The bench drives `rd_i` together with `msg_arrive_i` and then together with `tx_done_i`, and expects the new flag to survive while the other flags clear. It drives `rrb_i` together with `msg_arrive_i` while only the CPU buffer is full, and expects the arrival to refill the released slot. In that case `rbs_o` stays 1, the receive flag is raised and no swap is seen on `cpu_buf_o`.

// File: rtl/can_rxb_pkg.sv
package can_rxb_pkg;
  localparam int REG_W   = 8;
  localparam int NFLAG   = 5;
  localparam int RIF_BIT = 0;
  localparam int TIF_BIT = 1;
  localparam int EIF_BIT = 2;
  localparam int OIF_BIT = 3;
  localparam int WIF_BIT = 4;
endpackage

// File: rtl/can_rxb_track.sv
module can_rxb_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arrive_i,
  input  logic rrb_i,
  output logic rbs_o,
  output logic cpu_buf_o,
  output logic new_msg_o,
  output logic ovf_o
);
  logic cpu_full_q, pend_full_q, buf_q;
  logic cpu_rel, pend_rel, swap, fill_cpu;
  logic cpu_full_d, pend_full_d;

  always_comb begin
    swap        = rrb_i & pend_full_q;
    cpu_rel     = rrb_i ? pend_full_q : cpu_full_q;
    pend_rel    = rrb_i ? 1'b0 : pend_full_q;
    cpu_full_d  = cpu_rel;
    pend_full_d = pend_rel;
    fill_cpu    = 1'b0;
    ovf_o       = 1'b0;
    if (arrive_i) begin
      if (!cpu_rel) begin
        cpu_full_d = 1'b1;
        fill_cpu   = 1'b1;
      end else if (!pend_rel) begin
        pend_full_d = 1'b1;
      end else begin
        ovf_o = 1'b1; // both full: message dropped
      end
    end
    new_msg_o = swap | fill_cpu;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_full_q  <= 1'b0;
      pend_full_q <= 1'b0;
      buf_q       <= 1'b0;
    end else begin
      cpu_full_q  <= cpu_full_d;
      pend_full_q <= pend_full_d;
      if (swap) buf_q <= ~buf_q;
    end
  end

  assign rbs_o     = cpu_full_q;
  assign cpu_buf_o = buf_q;

  assert_rel_empty_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rrb_i && !pend_full_q && !arrive_i |=> !rbs_o && $stable(cpu_buf_o));
  assert_swap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rrb_i && pend_full_q |=> rbs_o && (cpu_buf_o != $past(cpu_buf_o)));
  assert_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arrive_i && !rrb_i && cpu_full_q && pend_full_q |=> rbs_o && pend_full_q);
  assert_fill_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arrive_i && !cpu_full_q |=> rbs_o);
endmodule

// File: rtl/can_rxb_wake.sv
module can_rxb_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic bus_act_i,
  output logic sleep_o,
  output logic wake_o
);
  logic sleep_q;

  assign wake_o = sleep_q & bus_act_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sleep_q <= 1'b0;
    else if (wake_o)      sleep_q <= 1'b0;
    else if (sleep_req_i) sleep_q <= 1'b1;
  end

  assign sleep_o = sleep_q;

  assert_wake_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o && bus_act_i |=> !sleep_o);
  assert_sleep_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_req_i && !bus_act_i |=> sleep_o);
endmodule

// File: rtl/can_rxb_intreg.sv
module can_rxb_intreg
  import can_rxb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] set_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] reg_o,
  output logic             irq_o
);
  localparam int PAD_W = REG_W - NFLAG;

  logic [NFLAG-1:0] flag_q;
  logic             arm_q;

  for (genvar k = 0; k < NFLAG; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[k] <= 1'b0;
      else if (set_i[k]) flag_q[k] <= 1'b1; // set beats read-clear
      else if (rd_i)     flag_q[k] <= 1'b0;
    end

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> flag_q[k]);
  end

  assign irq_o = arm_q & (|flag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    arm_q <= 1'b1;
    else if (rd_i)  arm_q <= 1'b1;
    else if (irq_o) arm_q <= 1'b0;
  end

  assign reg_o = {{PAD_W{1'b0}}, flag_q};

  assert_rd_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (set_i == '0) |=> (reg_o == '0));
  assert_irq_block_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !rd_i |=> !irq_o);
  assert_pad_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_o[REG_W-1:NFLAG] == '0);
endmodule

// File: rtl/can_rxb_ctrl.sv
module can_rxb_ctrl
  import can_rxb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             msg_arrive_i,
  input  logic             tx_done_i,
  input  logic             err_evt_i,
  input  logic             bus_act_i,
  input  logic             rrb_i,
  input  logic             rd_i,
  input  logic             sleep_req_i,
  output logic             sleep_o,
  output logic             rbs_o,
  output logic             cpu_buf_o,
  output logic             irq_o,
  output logic [REG_W-1:0] int_reg_o
);
  logic             new_msg, ovf, wake;
  logic [NFLAG-1:0] set_vec;

  can_rxb_track u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arrive_i  (msg_arrive_i),
    .rrb_i     (rrb_i),
    .rbs_o     (rbs_o),
    .cpu_buf_o (cpu_buf_o),
    .new_msg_o (new_msg),
    .ovf_o     (ovf)
  );

  can_rxb_wake u_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sleep_req_i (sleep_req_i),
    .bus_act_i   (bus_act_i),
    .sleep_o     (sleep_o),
    .wake_o      (wake)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[RIF_BIT] = new_msg;
    set_vec[TIF_BIT] = tx_done_i;
    set_vec[EIF_BIT] = err_evt_i;
    set_vec[OIF_BIT] = ovf;
    set_vec[WIF_BIT] = wake;
  end

  can_rxb_intreg u_intreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .rd_i   (rd_i),
    .reg_o  (int_reg_o),
    .irq_o  (irq_o)
  );

  assert_wake_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_o && bus_act_i |=> int_reg_o[WIF_BIT]);
  assert_awake_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_o && bus_act_i && rd_i |=> !int_reg_o[WIF_BIT]);
  assert_tx_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> int_reg_o[TIF_BIT]);
endmodule

// File: tb/can_rxb_ctrl_tb_top.sv
module can_rxb_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic arr = 0, tx = 0, err = 0, bus = 0, rrb = 0, rd = 0, slp = 0;
  logic sleep_o, rbs_o, cpu_buf_o, irq_o;
  logic [7:0] int_reg_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rxb_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .msg_arrive_i(arr), .tx_done_i(tx),
    .err_evt_i(err), .bus_act_i(bus), .rrb_i(rrb), .rd_i(rd),
    .sleep_req_i(slp), .sleep_o(sleep_o), .rbs_o(rbs_o),
    .cpu_buf_o(cpu_buf_o), .irq_o(irq_o), .int_reg_o(int_reg_o)
  );

  // {arrive,tx,err,rrb,rd} , exp rbs, exp cpu_buf, exp reg
  localparam logic [14:0] VEC [NVEC] = '{
    {5'b10000, 1'b1, 1'b0, 8'h01},  // R3 fill CPU buffer
    {5'b10000, 1'b1, 1'b0, 8'h01},  // R3 fill second buffer
    {5'b10000, 1'b1, 1'b0, 8'h09},  // R6 overrun
    {5'b00001, 1'b1, 1'b0, 8'h00},  // R2 read clears
    {5'b00010, 1'b1, 1'b1, 8'h01},  // R5 swap
    {5'b00010, 1'b0, 1'b1, 8'h01},  // R4 release, R6 drop confirmed
    {5'b01100, 1'b0, 1'b1, 8'h07},  // R7 tx and error
    {5'b10001, 1'b1, 1'b1, 8'h01},  // R10 arrival with read
    {5'b01001, 1'b1, 1'b1, 8'h02},  // R10 tx with read
    {5'b10010, 1'b1, 1'b1, 8'h03},  // release plus arrival refills
    {5'b00001, 1'b1, 1'b1, 8'h00}   // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    {arr, tx, err, rrb, rd, bus, slp} = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 reg", int_reg_o, 8'h00);
    chk("R11 rbs", rbs_o, 0);
    chk("R11 sleep", sleep_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      {arr, tx, err, rrb, rd} = VEC[i][14:10];
      step();
      chk($sformatf("R1 vec%0d reg", i), int_reg_o, VEC[i][7:0]);
      chk($sformatf("R3 R4 R5 vec%0d rbs", i), rbs_o, VEC[i][9]);
      chk($sformatf("R5 vec%0d cpu_buf", i), cpu_buf_o, VEC[i][8]);
    end

    // R9: one request, blocked until read
    tx = 1; step();
    chk("R9 irq fires", irq_o, 1);
    step();
    chk("R9 irq drops", irq_o, 0);
    err = 1; step();
    chk("R9 irq blocked", irq_o, 0);
    chk("R7 err flag", int_reg_o, 8'h06);
    rd = 1; step();
    chk("R9 after read", irq_o, 0);
    err = 1; step();
    chk("R9 rearmed", irq_o, 1);
    rd = 1; step();

    // R8: wake-up
    bus = 1; step();
    chk("R8 awake no wif", int_reg_o, 8'h00);
    chk("R8 awake sleep", sleep_o, 0);
    slp = 1; step();
    chk("R8 sleep set", sleep_o, 1);
    bus = 1; step();
    chk("R8 sleep cleared", sleep_o, 0);
    chk("R8 wif set", int_reg_o, 8'h10);
    rd = 1; step();
    chk("R2 wif cleared", int_reg_o, 8'h00);

    // R11: reset mid-run
    slp = 1; arr = 1; step();
    rst_ni = 0; #1;
    chk("R11 async reg", int_reg_o, 8'h00);
    chk("R11 async rbs", rbs_o, 0);
    chk("R11 async sleep", sleep_o, 0);
    chk("R11 async buf", cpu_buf_o, 0);
    @(negedge clk); rst_ni = 1; @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule